// File: doc/BRIEF.md
# Registered Product-Term Logic Array

This block is a configurable sum-of-products logic element of the kind found on small programmable array devices. A 64-row by 32-column connection map, written one 32-bit row at a time through a configuration port, decides which literals enter each of 64 AND terms. The terms are built over 16 array signals, and each signal is offered in true and in complement form. The 64 terms are split into eight groups of eight, and each group feeds one output.

The parameter `NUM_REG` (0, 4, 6 or 8) sets how many outputs are registered. The registered outputs are taken from the middle of the output order. A registered output ORs all eight of its terms into a flip-flop, drives the inverted flip-flop value, and feeds the flip-flop value back into the array. The other outputs are combinational: the first term of the group is the output's enable, the remaining seven are ORed and inverted, and the level seen at the pin feeds back.

A preload mode writes the state of one register directly from its pin level. This lets a test put a state machine built from the array into any state without stepping through its sequence.

Top module: `pal_array`

## Requirements
- R1: A synchronous reset sets every register to 1, so every registered `pin_out` bit reads 0. It clears the connection map. After reset, all `pin_oe` bits stay 0 until a configuration session (`cfg_mode` high for at least one cycle) has ended.
- R2: While `cfg_mode` is high and `cfg_we` is high, row `cfg_row` of the map takes `cfg_word` at the clock edge. Column 2k connects array signal k in true form and column 2k+1 connects it in complement form. Row 8j+t is term t of output j. A write while `cfg_mode` is low has no effect.
- R3: A term is the AND of every connected literal. A row with no connected column evaluates to 1. A row that connects both forms of the same signal evaluates to 0.
- R4: Array signals 0 to 7 are `dat_in[7:0]`. Signal 8+j is the feedback of output j: the register value for a registered output, `pin_in[j]` otherwise. With `NUM_REG` = 0, signal 8 is `aux_in` and signal 15 is `oe_n`.
- R5: Output j is registered when (8-NUM_REG)/2 <= j < 8-(8-NUM_REG)/2. Its register loads the OR of rows 8j..8j+7 at each rising clock edge, and `pin_out[j]` is the inverted register value.
- R6: On a combinational output j, `pin_oe[j]` is term 8j (once configured), and `pin_out[j]` is the NOR of terms 8j+1..8j+7.
- R7: A registered output is enabled only while `oe_n` is low, the block is configured and `cfg_mode` is low, and preload is off.
- R8: With `pre_en` high and `cfg_mode` low, the register selected by `pre_sel` loads the inverse of `pin_in[pre_sel]` at the clock edge, so its pin afterwards reads the applied level. All other registers hold, and all registered pins are disabled. A `pre_sel` that names a combinational output changes nothing.
- R9: While `cfg_mode` is high, every `pin_oe` bit is 0 and every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for registers and configuration |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | Configuration session active |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row being written |
| cfg_word | input | 32 | Connection bits for the row |
| dat_in | input | 8 | Dedicated array inputs |
| aux_in | input | 1 | Extra array input, used only when NUM_REG is 0 |
| oe_n | input | 1 | Active-low enable of registered pins; array input when NUM_REG is 0 |
| pre_en | input | 1 | Preload mode |
| pre_sel | input | 3 | Register chosen for preload |
| pin_in | input | 8 | Level seen at each output pin |
| pin_out | output | 8 | Value driven on each output pin |
| pin_oe | output | 8 | Drive enable of each output pin |

## Verification
Two functions can land on the same clock edge: a preload of one register and the normal array capture of every other register. The bench provokes this by raising `pre_en` on random cycles while the inputs and pin levels keep changing, so the unselected registers would load new sums if they were not held. It judges the result with a bench model that updates only the selected register, and it compares all eight pins on the following cycle. Configuration writes mixed with live evaluation are judged the same way: writes with `cfg_mode` low must leave every output as the unchanged map predicts.

// File: rtl/pal_pkg.sv
// Shared sizes and helpers for the product-term array.
// Assumes eight outputs with eight terms each, over sixteen array signals.
package pal_pkg;
    localparam int N_OUT = 8;
    localparam int N_TPO = 8;
    localparam int N_SIG = 16;
    localparam int N_COL = 2 * N_SIG;
    localparam int N_ROW = N_OUT * N_TPO;
    localparam int ROW_W = $clog2(N_ROW);
    localparam int SEL_W = $clog2(N_OUT);

    // True when output j is registered for a given register count.
    function automatic logic out_is_reg(input int num_reg, input int j);
        int edge_n;
        edge_n = (N_OUT - num_reg) / 2;
        return (j >= edge_n) && (j < N_OUT - edge_n);
    endfunction

    // Bit mask of the registered outputs.
    function automatic logic [N_OUT-1:0] reg_mask(input int num_reg);
        logic [N_OUT-1:0] m;
        for (int j = 0; j < N_OUT; j++) m[j] = out_is_reg(num_reg, j);
        return m;
    endfunction
endpackage

// File: rtl/pal_fuse_map.sv
// Connection-map storage: one word per product row.
// Assumes the write strobe is already qualified by the configuration session.
module pal_fuse_map #(
    parameter int N_ROW = 64,
    parameter int N_COL = 32,
    parameter int ROW_W = $clog2(N_ROW)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ROW_W-1:0]             wr_row,
    input  logic [N_COL-1:0]             wr_word,
    output logic [N_ROW-1:0][N_COL-1:0]  map_o
);
    // Clear on reset, otherwise write one row per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_o <= '0;
        end else if (wr_en) begin
            map_o[wr_row] <= wr_word;
        end
    end
endmodule

// File: rtl/pal_and_plane.sv
// AND plane: each row is the AND of the literals its map word connects.
// Column 2k is signal k, column 2k+1 its complement; an empty row is 1.
module pal_and_plane #(
    parameter int N_SIG = 16,
    parameter int N_ROW = 64,
    localparam int N_COL = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]             sig,
    input  logic [N_ROW-1:0][N_COL-1:0]  map_i,
    output logic [N_ROW-1:0]             terms
);
    logic [N_COL-1:0] lit;

    // Interleave the true and complement literals.
    always_comb begin
        for (int k = 0; k < N_SIG; k++) begin
            lit[2*k]     = sig[k];
            lit[2*k + 1] = ~sig[k];
        end
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        // Unconnected columns force a 1 into the AND.
        assign terms[r] = &(~map_i[r] | lit);
    end
endmodule

// File: rtl/pal_reg_cell.sv
// Output register: sums its term group, supports direct preload.
// Assumes preload and hold are decided by the caller; resets to 1.
module pal_reg_cell #(
    parameter int N_TPO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             pre_ld,
    input  logic             pre_bit,
    input  logic [N_TPO-1:0] sum_in,
    output logic             q
);
    // Reset high, preload inverted pin level, else capture the OR sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b1;
        end else if (pre_ld) begin
            q <= ~pre_bit;
        end else if (!hold) begin
            q <= |sum_in;
        end
    end
endmodule

// File: rtl/pal_array.sv
// Top of the configurable product-term array.
// Registers sit on the middle outputs; the rest are combinational outputs
// with a per-output enable term. Pins are modelled as value plus enable.
module pal_array
    import pal_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_row,
    input  logic [31:0]      cfg_word,
    input  logic [7:0]       dat_in,
    input  logic             aux_in,
    input  logic             oe_n,
    input  logic             pre_en,
    input  logic [2:0]       pre_sel,
    input  logic [7:0]       pin_in,
    output logic [7:0]       pin_out,
    output logic [7:0]       pin_oe
);
    localparam int N_IN = N_SIG - N_OUT;

    logic [N_ROW-1:0][N_COL-1:0] map_w;
    logic [N_ROW-1:0]            terms;
    logic [N_SIG-1:0]            sig;
    logic [N_OUT-1:0]            fb;
    logic                        cfg_seen;
    logic                        armed;
    logic                        hold_all;

    pal_fuse_map #(.N_ROW(N_ROW), .N_COL(N_COL), .ROW_W(ROW_W)) map_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_mode && cfg_we),
        .wr_row  (cfg_row),
        .wr_word (cfg_word),
        .map_o   (map_w)
    );

    pal_and_plane #(.N_SIG(N_SIG), .N_ROW(N_ROW)) plane_i (
        .sig   (sig),
        .map_i (map_w),
        .terms (terms)
    );

    // Remember that a configuration session has taken place since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_seen <= 1'b0;
        end else if (cfg_mode) begin
            cfg_seen <= 1'b1;
        end
    end

    assign armed    = cfg_seen && !cfg_mode;
    assign hold_all = cfg_mode || pre_en;
    assign sig[N_IN-1:0] = dat_in;

    for (genvar j = 0; j < N_OUT; j++) begin : g_sig
        if (NUM_REG == 0 && j == 0) begin : g_aux
            assign sig[N_IN + j] = aux_in;
        end else if (NUM_REG == 0 && j == N_OUT - 1) begin : g_oen
            assign sig[N_IN + j] = oe_n;
        end else begin : g_fb
            assign sig[N_IN + j] = fb[j];
        end
    end

    if (NUM_REG != 0) begin : g_aux_idle
        logic unused_aux;
        assign unused_aux = aux_in;
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        if (out_is_reg(NUM_REG, j)) begin : g_reg
            logic q;
            pal_reg_cell #(.N_TPO(N_TPO)) reg_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .hold    (hold_all),
                .pre_ld  (pre_en && !cfg_mode && (pre_sel == SEL_W'(j))),
                .pre_bit (pin_in[j]),
                .sum_in  (terms[j*N_TPO +: N_TPO]),
                .q       (q)
            );
            assign fb[j]      = q;
            assign pin_out[j] = ~q;
            assign pin_oe[j]  = armed && !oe_n && !pre_en;
        end else begin : g_cmb
            assign fb[j]      = pin_in[j];
            assign pin_oe[j]  = armed && terms[j*N_TPO];
            assign pin_out[j] = ~|terms[j*N_TPO + 1 +: N_TPO - 1];
        end
    end
endmodule

// File: rtl/pal_array_chk.sv
// Port-level properties of the product-term array, bound to the top.
// Assumes the synchronous active-low reset of the top.
module pal_array_chk
    import pal_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_mode,
    input logic       oe_n,
    input logic       pre_en,
    input logic [2:0] pre_sel,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe
);
    localparam logic [N_OUT-1:0] RM = reg_mask(NUM_REG);

    // R1
    reset_regs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((pin_out & RM) == '0));

    // R9
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> (pin_oe == '0));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_mode)) |-> ((pin_out & RM) == ($past(pin_out) & RM)));

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> ((pin_oe & RM) == '0));

    // R8
    pre_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> ((pin_oe & RM) == '0));

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pre_en) && !$past(cfg_mode)) |->
        ((pin_out & RM & ~(8'b1 << $past(pre_sel))) ==
         ($past(pin_out) & RM & ~(8'b1 << $past(pre_sel)))));
endmodule

bind pal_array pal_array_chk #(.NUM_REG(NUM_REG)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .oe_n     (oe_n),
    .pre_en   (pre_en),
    .pre_sel  (pre_sel),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/pal_array_tb.sv
// Self-checking bench: random and directed stimulus against a bench model.
module pal_array_tb_top;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n, cfg_mode, cfg_we, aux_in, oe_n, pre_en;
    logic [5:0]  cfg_row;
    logic [31:0] cfg_word;
    logic [7:0]  dat_in, pin_in, pin_out, pin_oe;
    logic [2:0]  pre_sel;

    logic [31:0] mmap [64];
    logic [7:0]  mq;
    logic        mseen;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    pal_array #(.NUM_REG(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_word(cfg_word), .dat_in(dat_in),
        .aux_in(aux_in), .oe_n(oe_n), .pre_en(pre_en), .pre_sel(pre_sel),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic bit isr(int j);
        return (j >= (8 - NR) / 2) && (j < 8 - (8 - NR) / 2);
    endfunction

    function automatic logic [15:0] msig();
        logic [15:0] s;
        s[7:0] = dat_in;
        for (int j = 0; j < 8; j++) begin
            if (isr(j))                  s[8+j] = mq[j];
            else if (NR == 0 && j == 0)  s[8+j] = aux_in;
            else if (NR == 0 && j == 7)  s[8+j] = oe_n;
            else                         s[8+j] = pin_in[j];
        end
        return s;
    endfunction

    function automatic logic mterm(int r, logic [15:0] s);
        logic [31:0] lit;
        for (int k = 0; k < 16; k++) begin
            lit[2*k] = s[k];
            lit[2*k+1] = ~s[k];
        end
        return &(~mmap[r] | lit);
    endfunction

    task automatic check_now(input string tag);
        logic [15:0] s;
        logic [7:0]  eo, ep;
        logic        armed, orv;
        #1;
        s = msig();
        armed = mseen && !cfg_mode;
        for (int j = 0; j < 8; j++) begin
            if (isr(j)) begin
                eo[j] = armed && !oe_n && !pre_en;
                ep[j] = ~mq[j];
            end else begin
                eo[j] = armed && mterm(8*j, s);
                orv = 1'b0;
                for (int t = 1; t < 8; t++) orv = orv | mterm(8*j + t, s);
                ep[j] = ~orv;
            end
        end
        checks++;
        if (pin_oe !== eo || pin_out !== ep) begin
            errors++;
            $display("FAIL %s: actual oe=%h out=%h expected oe=%h out=%h",
                     tag, pin_oe, pin_out, eo, ep);
        end
    endtask

    task automatic advance();
        logic [15:0] s;
        logic [7:0]  nq;
        logic        orv;
        s = msig();
        nq = mq;
        if (!rst_n) begin
            nq = 8'hFF;
        end else if (cfg_mode) begin
            nq = mq;
        end else if (pre_en) begin
            if (isr(int'(pre_sel))) nq[pre_sel] = ~pin_in[pre_sel];
        end else begin
            for (int j = 0; j < 8; j++) if (isr(j)) begin
                orv = 1'b0;
                for (int t = 0; t < 8; t++) orv = orv | mterm(8*j + t, s);
                nq[j] = orv;
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int r = 0; r < 64; r++) mmap[r] = '0;
            mseen = 1'b0;
        end else if (cfg_mode) begin
            mseen = 1'b1;
            if (cfg_we) mmap[cfg_row] = cfg_word;
        end
        mq = nq;
        @(negedge clk);
    endtask

    task automatic rnd_pins();
        dat_in = 8'($urandom);
        aux_in = 1'($urandom);
        pin_in = 8'($urandom);
    endtask

    function automatic logic [31:0] sparse();
        return $urandom & $urandom & $urandom;
    endfunction

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        rst_n = 1'b0; cfg_mode = 0; cfg_we = 0; cfg_row = '0; cfg_word = '0;
        dat_in = '0; aux_in = 0; oe_n = 1; pre_en = 0; pre_sel = '0; pin_in = '0;
        for (int r = 0; r < 64; r++) mmap[r] = '0;
        mq = 8'hFF; mseen = 0;
        @(negedge clk);
        repeat (3) advance();
        rst_n = 1'b1;
        check_now("R1 reset state");
        // R1: never configured, outputs stay disabled
        oe_n = 0;
        repeat (4) begin rnd_pins(); check_now("R1 unconfigured"); advance(); end
        // R2/R9: configuration session with directed and random rows
        cfg_mode = 1;
        for (int r = 0; r < 64; r++) begin
            cfg_we = 1; cfg_row = 6'(r);
            if (r == 0)                   cfg_word = 32'h0;       // R3 empty -> 1
            else if (r < 8 || r >= 58)    cfg_word = 32'h3;       // R3 contradiction -> 0
            else if (r == 56)             cfg_word = 32'h1;       // enable = signal 0
            else if (r == 57)             cfg_word = 32'h4;       // term = signal 1
            else if ($urandom % 8 == 0)   cfg_word = 32'h0;
            else                          cfg_word = sparse();
            rnd_pins();
            check_now("R9 config session");
            advance();
        end
        cfg_we = 0; cfg_mode = 0;
        // R3/R4/R5/R6/R7: normal operation
        repeat (300) begin
            rnd_pins(); oe_n = ($urandom % 8 == 0);
            check_now("R3/R4/R5/R6/R7 run");
            advance();
        end
        oe_n = 0;
        // R2: writes outside a session are ignored
        repeat (40) begin
            rnd_pins(); cfg_we = 1; cfg_row = 6'($urandom); cfg_word = $urandom;
            check_now("R2 ignored write");
            advance();
        end
        cfg_we = 0;
        // R8: preload every output index, registered or not
        for (int sel = 0; sel < 8; sel++) begin
            rnd_pins(); pre_en = 1; pre_sel = 3'(sel);
            check_now("R8 preload");
            advance();
        end
        pre_en = 0;
        check_now("R8 preload readback");
        // R8/R5: preload and capture mixed at random
        repeat (400) begin
            rnd_pins();
            pre_en = ($urandom % 6 == 0); pre_sel = 3'($urandom);
            cfg_we = 1'($urandom); cfg_row = 6'($urandom); cfg_word = $urandom;
            oe_n = ($urandom % 10 == 0);
            check_now("R2/R5/R7/R8 mixed");
            advance();
        end
        pre_en = 0; cfg_we = 0; oe_n = 0;
        // R2/R9: second session rewrites rows
        cfg_mode = 1;
        repeat (20) begin
            rnd_pins(); cfg_we = 1; cfg_row = 6'($urandom); cfg_word = sparse();
            check_now("R2/R9 reconfigure");
            advance();
        end
        cfg_mode = 0; cfg_we = 0;
        repeat (100) begin
            rnd_pins();
            check_now("R5/R6 after reconfigure");
            advance();
        end
        // R1: reset during operation
        rst_n = 0;
        advance();
        rst_n = 1;
        rnd_pins();
        check_now("R1 reset mid-run");
        advance();
        check_now("R1 disabled after reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule